// File: doc/BRIEF.md
# Chip-Select Output Controller

This block owns a small bank of general-purpose output pins that a serial-peripheral master uses as chip selects. Each pin carries two configuration bits: one marks it as a chip select, which ties its level changes to the shift engine's transfer activity, and one inverts its driven level so that an active-low select becomes active-high. A separate level port changes the stored output bits. Every bit of a level write is either a set request, a clear request or no request, so software can move one select without disturbing the others.

While the shift engine reports a transfer in flight, level changes aimed at chip-select pins are parked in a one-entry pending slot per pin. They reach the pin at the first clock edge when that pin is no longer held. Plain output pins always follow level writes at once. A readback port returns the stored output bits before inversion.

Top module: `cs_out_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every stored output bit reads 1, every configuration bit is 0, and every pin drives 1.
- R2: A control write stores data bits 15:8 as the per-pin chip-select mode bits and data bits 7:0 as the per-pin inversion bits, and then each pin drives its stored bit XOR its inversion bit.
- R3: A level write with data bit 8+i at 1 makes stored bit i read 1 after the next clock edge, unless that pin is held.
- R4: A level write with data bit i at 1 and data bit 8+i at 0 makes stored bit i read 0 after the next clock edge, unless that pin is held.
- R5: A pin whose set and clear bits are both 0 in a level write keeps its stored bit.
- R6: When set and clear are both 1 for the same pin in one write, the stored bit becomes 1.
- R7: The readback port returns the 8 stored output bits and is not affected by the inversion bits.
- R8: A pin is held while transfer-active is 1 and its chip-select mode bit is 1. A held pin's stored bit does not change, while plain-mode pins still follow level writes in the same cycle.
- R9: A level request made to a held pin takes effect at the first clock edge when the pin is no longer held. If a direct level request for that pin arrives in the same cycle, the direct request takes effect instead.
- R10: When several level writes reach a held pin, the last request for that pin is the one applied. A later write with both of that pin's bits at 0 does not cancel an earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: [15:8] chip-select mode, [7:0] inversion |
| lvl_we | input | 1 | Level write strobe |
| lvl_wdata | input | 16 | Level word: [15:8] set requests, [7:0] clear requests |
| xfer_active | input | 1 | Shift engine transfer in progress |
| pin_out | output | 8 | Driven pin levels |
| state_out | output | 8 | Readback of the stored output bits |

## Verification
On every cycle the assertions check the per-pin rules. A set request on a free pin lands, a lone clear lands, set beats clear, and a held pin's stored bit stays frozen. A pin with no request and nothing pending stays steady. The deferred path cannot be seen in a single cycle, so only the bench scenarios show it. These cover requests parked across several writes and applied when the transfer ends, a direct write that overrides a parked one, and the pin level under different inversion settings. A randomized run compares both outputs every cycle against a bench-side model built from the requirements.

// File: rtl/cs_out_pkg.sv
package cs_out_pkg;
  localparam int unsigned CS_PINS_DEF = 8;

  typedef struct packed {
    logic wr;
    logic set;
    logic clr;
  } lvl_req_t;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg #(
  parameter int unsigned N = 8,
  localparam int unsigned W = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [N-1:0] cs_mode,
  output logic [N-1:0] invert
);
  logic [N-1:0] mode_q, mode_d;
  logic [N-1:0] inv_q, inv_d;

  always_comb begin
    mode_d = mode_q;
    inv_d  = inv_q;
    if (we) begin
      mode_d = wdata[W-1:N];
      inv_d  = wdata[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      inv_q  <= '0;
    end else begin
      mode_q <= mode_d;
      inv_q  <= inv_d;
    end
  end

  assign cs_mode = mode_q;
  assign invert  = inv_q;
endmodule

// File: rtl/cs_pin_cell.sv
module cs_pin_cell
  import cs_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_req_t req,
  input  logic     cs_mode,
  input  logic     invert,
  input  logic     xfer_active,
  output logic     stored,
  output logic     pending,
  output logic     pin
);
  logic st_q, st_d;
  logic pv_q, pv_d;
  logic pval_q, pval_d;
  logic hit, held;

  always_comb begin
    hit    = req.wr && (req.set || req.clr);
    held   = xfer_active && cs_mode;
    st_d   = st_q;
    pv_d   = pv_q;
    pval_d = pval_q;
    if (held) begin
      if (hit) begin
        pv_d   = 1'b1;
        pval_d = req.set;
      end
    end else if (hit) begin
      st_d = req.set;
      pv_d = 1'b0;
    end else if (pv_q) begin
      st_d = pval_q;
      pv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b1;
      pv_q   <= 1'b0;
      pval_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pv_q   <= pv_d;
      pval_q <= pval_d;
    end
  end

  assign stored  = st_q;
  assign pending = pv_q;
  assign pin     = st_q ^ invert;
endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
  import cs_out_pkg::*;
#(
  parameter int unsigned N = CS_PINS_DEF,
  localparam int unsigned W = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [W-1:0] ctrl_wdata,
  input  logic         lvl_we,
  input  logic [W-1:0] lvl_wdata,
  input  logic         xfer_active,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] state_out
);
  logic         rst_q_n;
  logic [N-1:0] cs_mode;
  logic [N-1:0] invert;
  logic [N-1:0] pend;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cs_ctrl_reg #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we      (ctrl_we),
    .wdata   (ctrl_wdata),
    .cs_mode (cs_mode),
    .invert  (invert)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    lvl_req_t req;
    always_comb begin
      req.wr  = lvl_we;
      req.set = lvl_wdata[N+i];
      req.clr = lvl_wdata[i];
    end

    cs_pin_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .req         (req),
      .cs_mode     (cs_mode[i]),
      .invert      (invert[i]),
      .xfer_active (xfer_active),
      .stored      (state_out[i]),
      .pending     (pend[i]),
      .pin         (pin_out[i])
    );
  end
endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk #(
  parameter int unsigned N = 8,
  localparam int unsigned W = 2 * N
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         lvl_we,
  input logic [W-1:0] lvl_wdata,
  input logic         xfer_active,
  input logic [N-1:0] cs_mode,
  input logic [N-1:0] pend,
  input logic [N-1:0] state_out
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lvl_we && lvl_wdata[N+i] && !(xfer_active && cs_mode[i])) |=> state_out[i]);

    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lvl_we && lvl_wdata[i] && !lvl_wdata[N+i] && !(xfer_active && cs_mode[i]))
        |=> !state_out[i]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lvl_we && lvl_wdata[i] && lvl_wdata[N+i] && !(xfer_active && cs_mode[i]))
        |=> state_out[i]);

    assert_held_frozen_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
      (xfer_active && cs_mode[i]) |=> $stable(state_out[i]));

    assert_idle_steady_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!(lvl_we && (lvl_wdata[i] || lvl_wdata[N+i])) && !pend[i]) |=> $stable(state_out[i]));
  end
endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .lvl_we      (lvl_we),
  .lvl_wdata   (lvl_wdata),
  .xfer_active (xfer_active),
  .cs_mode     (cs_mode),
  .pend        (pend),
  .state_out   (state_out)
);

// File: tb/tb_cs_out_ctrl.sv
module tb_cs_out_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ctrl_we;
  logic [15:0]  ctrl_wdata;
  logic         lvl_we;
  logic [15:0]  lvl_wdata;
  logic         xfer_active;
  logic [7:0]   pin_out;
  logic [7:0]   state_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] m_st, m_pv, m_pval, m_mode, m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_out_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .xfer_active(xfer_active),
    .pin_out(pin_out), .state_out(state_out)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_step(input logic cw, input logic [15:0] cd,
                                     input logic lw, input logic [15:0] ld,
                                     input logic x);
    for (int i = 0; i < N; i++) begin
      logic s, c, hit;
      s = ld[N+i];
      c = ld[i];
      hit = lw && (s || c);
      if (x && m_mode[i]) begin
        if (hit) begin m_pv[i] = 1'b1; m_pval[i] = s; end
      end else if (hit) begin
        m_st[i] = s; m_pv[i] = 1'b0;
      end else if (m_pv[i]) begin
        m_st[i] = m_pval[i]; m_pv[i] = 1'b0;
      end
    end
    if (cw) begin
      m_mode = cd[15:8];
      m_inv  = cd[7:0];
    end
  endfunction

  task automatic step(input logic cw, input logic [15:0] cd,
                      input logic lw, input logic [15:0] ld, input logic x);
    @(negedge clk);
    ctrl_we = cw; ctrl_wdata = cd; lvl_we = lw; lvl_wdata = ld; xfer_active = x;
    model_step(cw, cd, lw, ld, x);
    @(posedge clk);
    #1;
    ctrl_we = 1'b0; lvl_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; lvl_we = 1'b0;
    lvl_wdata = '0; xfer_active = 1'b0;
    m_st = 8'hFF; m_pv = '0; m_pval = '0; m_mode = '0; m_inv = '0;
    repeat (3) @(posedge clk);
    #1;
    chk8("R1 state in reset", state_out, 8'hFF);
    chk8("R1 pins in reset", pin_out, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk8("R1 state after reset", state_out, 8'hFF);
    chk8("R1 pins after reset", pin_out, 8'hFF);

    step(0, 0, 1, 16'h00FF, 0); chk8("R4 clear all", state_out, 8'h00);
    step(0, 0, 1, 16'h0500, 0); chk8("R3 set 0 and 2", state_out, 8'h05);
    step(0, 0, 1, 16'h0000, 0); chk8("R5 zero write", state_out, 8'h05);
    step(0, 0, 1, 16'h0202, 0); chk8("R6 set wins", state_out, 8'h07);
    step(1, 16'h00F0, 0, 0, 0);
    chk8("R2 inverted pins", pin_out, 8'hF7);
    chk8("R7 readback ignores inversion", state_out, 8'h07);
    step(1, 16'h0F00, 0, 0, 0); chk8("R2 inversion off", pin_out, 8'h07);
    step(0, 0, 1, 16'h3001, 1); chk8("R8 held vs plain", state_out, 8'h37);
    step(0, 0, 1, 16'h0100, 1); chk8("R8 held set", state_out, 8'h37);
    step(0, 0, 1, 16'h0002, 1); chk8("R10 later held clear", state_out, 8'h37);
    step(0, 0, 1, 16'h0000, 1); chk8("R10 zero write keeps pending", state_out, 8'h37);
    step(0, 0, 0, 0, 0); chk8("R9 pending applied", state_out, 8'h35);
    step(0, 0, 1, 16'h0004, 1); chk8("R8 held clear bit2", state_out, 8'h35);
    step(0, 0, 1, 16'h0400, 0); chk8("R9 direct overrides pending", state_out, 8'h35);
    step(0, 0, 0, 0, 0); chk8("R9 no stale pending", state_out, 8'h35);

    for (int n = 0; n < 3000; n++) begin
      logic cw, lw, x;
      logic [15:0] cd, ld;
      cw = ($urandom % 16) == 0;
      cd = 16'($urandom);
      lw = $urandom % 2;
      ld = 16'($urandom & $urandom);
      x  = ($urandom % 3) != 0;
      step(cw, cd, lw, ld, x);
      chk8("R7 random readback", state_out, m_st);
      chk8("R2 random pins", pin_out, m_st ^ m_inv);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule